// File: doc/BRIEF.md
# Host command mailbox

This block is a memory-mapped mailbox. A host processor uses it to hand a command to a service controller and to collect the outcome. The host side is a plain 32-bit register port with write and read strobes. The host first loads the source and destination pointers and up to four words of input data. It then writes the command word, which carries an 8-bit opcode, a 4-bit subcommand, an input byte length and a flag that asks for an interrupt on completion.

Writing the command word sets the busy flag, and busy drives the request line toward the service controller. For as long as the request is up, the opcode, the fields, both pointers and the input buffer are frozen and shown on the service port. The service side ends the command with a one-cycle done pulse. With that pulse it returns an error flag, an error code and four words of response data. The response data fills the read buffer. If the finished command asked for one, an interrupt-pending flag is raised and drives the interrupt output. The host clears that flag with a write-1-to-clear.

Top module: `hcmd_mailbox`

## Requirements
- R1: While reset is applied and just after it is released, the registers and buffers read as zero, and `svc_req`, `irq` and `h_rdata` are 0.
- R2: A host write to offset 0x00 while not busy stores the command word and raises `svc_req` after that clock edge. The fields are: opcode in bits 7:0 on `svc_cmd`, interrupt request in bit 8, subcommand in bits 15:12 on `svc_sub`, and input byte length in bits 20:16 on `svc_len`. Reading offset 0x00 returns the stored fields, with bits 11:9 and 31:21 read as zero.
- R3: Status bit 0 (busy, the same as `svc_req`) stays 1 until a `svc_done` pulse. It reads 0 from the edge that samples the pulse.
- R4: On completion, status bit 1 takes `svc_err`. Status bits 23:16 take `svc_code` when `svc_err` is 1 and read 0 otherwise. Error codes 0 to 7 stand for: none, unsupported, not serviced, unable to service, invalid, failed, security rejection and unsigned-image rejection. A newly accepted command clears both the error bit and the code.
- R5: On completion, status bit 2 (pending) and `irq` are set only if the command had bit 8 set. They stay set until the host writes offset 0x04 with bit 2 equal to 1. A status write with bit 2 equal to 0 has no effect on them.
- R6: While busy, host writes to the command register, to the pointer registers and to the write buffer are ignored.
- R7: The source pointer at 0x08 and the destination pointer at 0x0C read back as written and drive `svc_sptr` and `svc_dptr`.
- R8: Write-buffer word i sits at offset 0x80+4*i (i = 0 to 3). It reads back at that offset and appears on `svc_wbuf` bits 32*i+31:32*i.
- R9: Read-buffer word i at offset 0x90+4*i is loaded from `svc_rdata` bits 32*i+31:32*i on completion. Host writes to it have no effect.
- R10: Read data appears on `h_rdata` after the clock edge that samples `h_rd`, and holds until the next read. Reads of unmapped offsets return 0. An access whose address bits 1:0 are not 00 is ignored and reads 0.
- R11: A `svc_done` pulse while not busy changes neither the status nor the read buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| irq | output | 1 | Completion interrupt (pending flag) |
| svc_req | output | 1 | Command request to service side |
| svc_cmd | output | 8 | Command opcode |
| svc_sub | output | 4 | Subcommand |
| svc_len | output | LENW | Input length in bytes |
| svc_sptr | output | 32 | Source pointer |
| svc_dptr | output | 32 | Destination pointer |
| svc_wbuf | output | 32*BUF_WORDS | Input data words, word 0 in the low bits |
| svc_done | input | 1 | Completion pulse |
| svc_err | input | 1 | Error flag with completion |
| svc_code | input | 8 | Error code with completion |
| svc_rdata | input | 32*BUF_WORDS | Response data words, word 0 in the low bits |

## Verification
A host write takes effect at the edge that samples it, so `svc_req`, the service fields and `irq` are checked half a cycle after the write strobe drops. A register read has one cycle of latency. The bench raises `h_rd` on a falling edge and samples `h_rdata` on the next falling edge. It also checks that the old value is still present before the capturing edge. A done pulse acts on the edge that samples it, so busy, error, code, pending and read-buffer contents are checked from the falling edge after the pulse onward. The sweep covers every error code against both settings of the interrupt-request bit, with expected words built arithmetically from the loop indices.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  localparam int DW = 32;

  // Register offsets (bytes)
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STS  = 8'h04;
  localparam logic [7:0] OFS_SPTR = 8'h08;
  localparam logic [7:0] OFS_DPTR = 8'h0C;
  localparam logic [7:0] OFS_WBUF = 8'h80;
  localparam logic [7:0] OFS_RBUF = 8'h90;

  // Field positions
  localparam int CMD_IRQ_BIT  = 8;
  localparam int CMD_SUB_LSB  = 12;
  localparam int CMD_LEN_LSB  = 16;
  localparam int STS_IP_BIT   = 2;

  typedef enum logic [7:0] {
    HMB_OK           = 8'd0,
    HMB_UNSUPPORTED  = 8'd1,
    HMB_NOT_SERVICED = 8'd2,
    HMB_CANT_SERVICE = 8'd3,
    HMB_BAD_CMD      = 8'd4,
    HMB_FAILED       = 8'd5,
    HMB_SECURITY     = 8'd6,
    HMB_UNSIGNED     = 8'd7
  } hmb_err_e;
endpackage

// File: rtl/hmb_wordbuf.sv
module hmb_wordbuf #(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic                load_en,
  input  logic [WORDS*DW-1:0] load_data,
  output logic [WORDS*DW-1:0] words_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_d;
    logic [DW-1:0] word_q;

    always_comb begin
      word_d = word_q;
      if (load_en)
        word_d = load_data[g*DW +: DW];
      else if (wr_en && (wr_idx == IW'(g)))
        word_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign words_o[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/hmb_ctrl.sv
module hmb_ctrl #(
  parameter int LENW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic [7:0]      cmd_op_i,
  input  logic [3:0]      cmd_sub_i,
  input  logic [LENW-1:0] cmd_len_i,
  input  logic            cmd_irq_i,
  input  logic            ip_clr,
  input  logic            svc_done,
  input  logic            svc_err,
  input  logic [7:0]      svc_code,
  output logic            busy_o,
  output logic            err_o,
  output logic            ip_o,
  output logic [7:0]      code_o,
  output logic [7:0]      op_o,
  output logic [3:0]      sub_o,
  output logic [LENW-1:0] len_o,
  output logic            irq_en_o,
  output logic            finish_o
);
  logic            busy_q, busy_d;
  logic            err_q, err_d;
  logic            ip_q, ip_d;
  logic            irq_en_q, irq_en_d;
  logic [7:0]      code_q, code_d;
  logic [7:0]      op_q, op_d;
  logic [3:0]      sub_q, sub_d;
  logic [LENW-1:0] len_q, len_d;
  logic            accept;
  logic            finish;

  assign accept = cmd_we && !busy_q;
  assign finish = svc_done && busy_q;

  always_comb begin
    busy_d   = busy_q;
    err_d    = err_q;
    ip_d     = ip_q;
    irq_en_d = irq_en_q;
    code_d   = code_q;
    op_d     = op_q;
    sub_d    = sub_q;
    len_d    = len_q;
    if (ip_clr)
      ip_d = 1'b0;
    if (accept) begin
      busy_d   = 1'b1;
      err_d    = 1'b0;
      code_d   = 8'h00;
      op_d     = cmd_op_i;
      sub_d    = cmd_sub_i;
      len_d    = cmd_len_i;
      irq_en_d = cmd_irq_i;
    end else if (finish) begin
      busy_d = 1'b0;
      err_d  = svc_err;
      code_d = svc_err ? svc_code : 8'h00;
      if (irq_en_q)
        ip_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      ip_q     <= 1'b0;
      irq_en_q <= 1'b0;
      code_q   <= '0;
      op_q     <= '0;
      sub_q    <= '0;
      len_q    <= '0;
    end else begin
      busy_q   <= busy_d;
      err_q    <= err_d;
      ip_q     <= ip_d;
      irq_en_q <= irq_en_d;
      code_q   <= code_d;
      op_q     <= op_d;
      sub_q    <= sub_d;
      len_q    <= len_d;
    end
  end

  assign busy_o   = busy_q;
  assign err_o    = err_q;
  assign ip_o     = ip_q;
  assign code_o   = code_q;
  assign op_o     = op_q;
  assign sub_o    = sub_q;
  assign len_o    = len_q;
  assign irq_en_o = irq_en_q;
  assign finish_o = finish;

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !svc_done) |=> busy_q); // R3
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && svc_done) |=> !busy_q); // R3
  AST_IP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ip_q) |-> $past(busy_q && svc_done && irq_en_q)); // R5
  AST_NEW_CMD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (!err_q && (code_q == 8'h00))); // R4
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_we) |=> ($stable(op_q) && $stable(sub_q) && $stable(len_q))); // R6
endmodule

// File: rtl/hcmd_mailbox.sv
module hcmd_mailbox #(
  parameter int ADDR_W    = 8,
  parameter int BUF_WORDS = 4,
  localparam int LENW     = $clog2(BUF_WORDS*4+1),
  localparam int IDXW     = $clog2(BUF_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    h_wr,
  input  logic                    h_rd,
  input  logic [ADDR_W-1:0]       h_addr,
  input  logic [31:0]             h_wdata,
  output logic [31:0]             h_rdata,
  output logic                    irq,
  output logic                    svc_req,
  output logic [7:0]              svc_cmd,
  output logic [3:0]              svc_sub,
  output logic [LENW-1:0]         svc_len,
  output logic [31:0]             svc_sptr,
  output logic [31:0]             svc_dptr,
  output logic [BUF_WORDS*32-1:0] svc_wbuf,
  input  logic                    svc_done,
  input  logic                    svc_err,
  input  logic [7:0]              svc_code,
  input  logic [BUF_WORDS*32-1:0] svc_rdata
);
  import hmb_pkg::*;

  localparam int RGN_LSB = IDXW + 2;
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_SPTR = ADDR_W'(OFS_SPTR);
  localparam logic [ADDR_W-1:0] A_DPTR = ADDR_W'(OFS_DPTR);
  localparam logic [ADDR_W-1:0] A_WBUF = ADDR_W'(OFS_WBUF);
  localparam logic [ADDR_W-1:0] A_RBUF = ADDR_W'(OFS_RBUF);

  logic                    aligned;
  logic                    sel_cmd, sel_sts, sel_sptr, sel_dptr, sel_wbuf, sel_rbuf;
  logic [IDXW-1:0]         buf_idx;
  logic                    busy, err, ip, irq_en, finish;
  logic [7:0]              code, op;
  logic [3:0]              sub;
  logic [LENW-1:0]         len;
  logic                    host_ok;
  logic [31:0]             sptr_q, sptr_d, dptr_q, dptr_d;
  logic [31:0]             rdata_q, rdata_d, rd_word;
  logic [31:0]             cmd_word, sts_word;
  logic [BUF_WORDS*32-1:0] wbuf_flat, rbuf_flat;

  // Address decode
  assign aligned  = (h_addr[1:0] == 2'b00);
  assign sel_cmd  = aligned && (h_addr == A_CMD);
  assign sel_sts  = aligned && (h_addr == A_STS);
  assign sel_sptr = aligned && (h_addr == A_SPTR);
  assign sel_dptr = aligned && (h_addr == A_DPTR);
  assign sel_wbuf = aligned && (h_addr[ADDR_W-1:RGN_LSB] == A_WBUF[ADDR_W-1:RGN_LSB]);
  assign sel_rbuf = aligned && (h_addr[ADDR_W-1:RGN_LSB] == A_RBUF[ADDR_W-1:RGN_LSB]);
  assign buf_idx  = h_addr[RGN_LSB-1:2];
  assign host_ok  = h_wr && !busy;

  hmb_ctrl #(.LENW(LENW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (h_wr && sel_cmd),
    .cmd_op_i  (h_wdata[7:0]),
    .cmd_sub_i (h_wdata[CMD_SUB_LSB +: 4]),
    .cmd_len_i (h_wdata[CMD_LEN_LSB +: LENW]),
    .cmd_irq_i (h_wdata[CMD_IRQ_BIT]),
    .ip_clr    (h_wr && sel_sts && h_wdata[STS_IP_BIT]),
    .svc_done  (svc_done),
    .svc_err   (svc_err),
    .svc_code  (svc_code),
    .busy_o    (busy),
    .err_o     (err),
    .ip_o      (ip),
    .code_o    (code),
    .op_o      (op),
    .sub_o     (sub),
    .len_o     (len),
    .irq_en_o  (irq_en),
    .finish_o  (finish)
  );

  hmb_wordbuf #(.DW(32), .WORDS(BUF_WORDS)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (host_ok && sel_wbuf),
    .wr_idx    (buf_idx),
    .wr_data   (h_wdata),
    .load_en   (1'b0),
    .load_data ('0),
    .words_o   (wbuf_flat)
  );

  hmb_wordbuf #(.DW(32), .WORDS(BUF_WORDS)) u_rbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (1'b0),
    .wr_idx    ('0),
    .wr_data   ('0),
    .load_en   (finish),
    .load_data (svc_rdata),
    .words_o   (rbuf_flat)
  );

  // Pointer registers
  always_comb begin
    sptr_d = sptr_q;
    dptr_d = dptr_q;
    if (host_ok && sel_sptr) sptr_d = h_wdata;
    if (host_ok && sel_dptr) dptr_d = h_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sptr_q <= '0;
      dptr_q <= '0;
    end else begin
      sptr_q <= sptr_d;
      dptr_q <= dptr_d;
    end
  end

  // Read path
  assign cmd_word = {{(16-LENW){1'b0}}, len, sub, 3'b000, irq_en, op};
  assign sts_word = {8'h00, code, 13'h0000, ip, err, busy};

  always_comb begin
    rd_word = '0;
    if (sel_cmd)       rd_word = cmd_word;
    else if (sel_sts)  rd_word = sts_word;
    else if (sel_sptr) rd_word = sptr_q;
    else if (sel_dptr) rd_word = dptr_q;
    else if (sel_wbuf) rd_word = wbuf_flat[buf_idx*32 +: 32];
    else if (sel_rbuf) rd_word = rbuf_flat[buf_idx*32 +: 32];
  end

  always_comb begin
    rdata_d = rdata_q;
    if (h_rd) rdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign h_rdata  = rdata_q;
  assign irq      = ip;
  assign svc_req  = busy;
  assign svc_cmd  = op;
  assign svc_sub  = sub;
  assign svc_len  = len;
  assign svc_sptr = sptr_q;
  assign svc_dptr = dptr_q;
  assign svc_wbuf = wbuf_flat;

  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && h_wr) |=> ($stable(svc_sptr) && $stable(svc_dptr))); // R6
  AST_WBUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && $past(svc_req)) |-> $stable(svc_wbuf)); // R6
  AST_RBUF_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(rbuf_flat)); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(h_wr && sel_sts && h_wdata[STS_IP_BIT])) |=> irq); // R5
endmodule

// File: tb/sim_hcmd_mailbox.sv
`timescale 1ns/1ps
module sim_hcmd_mailbox;
  import hmb_pkg::*;

  localparam int NW = 4;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          h_wr, h_rd;
  logic [7:0]    h_addr;
  logic [31:0]   h_wdata;
  logic [31:0]   h_rdata;
  logic          irq, svc_req;
  logic [7:0]    svc_cmd;
  logic [3:0]    svc_sub;
  logic [LW-1:0] svc_len;
  logic [31:0]   svc_sptr, svc_dptr;
  logic [NW*32-1:0] svc_wbuf, svc_rdata;
  logic          svc_done, svc_err;
  logic [7:0]    svc_code;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hcmd_mailbox #(.ADDR_W(8), .BUF_WORDS(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .irq(irq), .svc_req(svc_req),
    .svc_cmd(svc_cmd), .svc_sub(svc_sub), .svc_len(svc_len),
    .svc_sptr(svc_sptr), .svc_dptr(svc_dptr), .svc_wbuf(svc_wbuf),
    .svc_done(svc_done), .svc_err(svc_err), .svc_code(svc_code),
    .svc_rdata(svc_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_rd = 1'b1;
    @(negedge clk);
    h_rd = 1'b0;
    d = h_rdata;
  endtask

  task automatic complete(input logic e, input logic [7:0] c, input logic [NW*32-1:0] data);
    @(negedge clk);
    svc_done = 1'b1; svc_err = e; svc_code = c; svc_rdata = data;
    @(negedge clk);
    svc_done = 1'b0;
  endtask

  function automatic logic [31:0] wpat(int e, int q, int i);
    return {8'hA5, 8'(e), 8'(q), 8'(i)};
  endfunction

  function automatic logic [31:0] rpat(int e, int q, int i);
    return {8'h5C, 8'(i), 8'(e), 8'(q)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [NW*32-1:0] rdat;
    h_wr = 0; h_rd = 0; h_addr = '0; h_wdata = '0;
    svc_done = 0; svc_err = 0; svc_code = '0; svc_rdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 svc_req in reset", {31'd0, svc_req}, 32'd0);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    check("R1 h_rdata in reset", h_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    hread(OFS_STS, r);  check("R1 status after reset", r, 32'd0);
    hread(OFS_CMD, r);  check("R1 command after reset", r, 32'd0);
    hread(OFS_SPTR, r); check("R1 sptr after reset", r, 32'd0);
    hread(OFS_WBUF, r); check("R1 wbuf after reset", r, 32'd0);
    hread(OFS_RBUF, r); check("R1 rbuf after reset", r, 32'd0);

    // R10: misaligned, unmapped, latency
    hwrite(8'h08, 32'hCAFE_F00D);
    hwrite(8'h09, 32'h1111_1111);
    hread(8'h08, r); check("R10 misaligned write ignored", r, 32'hCAFE_F00D);
    hread(8'h09, r); check("R10 misaligned read zero", r, 32'd0);
    hread(8'h08, r);
    @(negedge clk);
    h_addr = 8'h40; h_rd = 1'b1;
    #1 check("R10 old data held before edge", h_rdata, 32'hCAFE_F00D);
    @(negedge clk);
    h_rd = 1'b0;
    check("R10 unmapped read zero", h_rdata, 32'd0);
    repeat (2) @(negedge clk);
    check("R10 data held without read", h_rdata, 32'd0);

    for (int e = 0; e < 8; e++) begin
      for (int q = 0; q < 2; q++) begin
        logic [7:0]  op;
        logic [3:0]  sb;
        logic [4:0]  ln;
        logic [31:0] cw, sp, dp, sts_exp;
        logic [7:0]  code_exp;
        op = 8'(8'h21 + e*16 + q*3);
        sb = 4'(e + q*8);
        ln = 5'((e*2 + q*5) % 17);
        sp = 32'h1000_0000 + 32'(e*256 + q);
        dp = 32'h2000_0000 + 32'(e*256 + q);
        cw = (32'(ln) << 16) | (32'(sb) << 12) | (32'(q) << 8) | 32'(op);

        hwrite(OFS_SPTR, sp);
        hwrite(OFS_DPTR, dp);
        for (int i = 0; i < NW; i++) hwrite(8'(OFS_WBUF + 4*i), wpat(e, q, i));
        hwrite(OFS_CMD, cw | 32'h0000_0E00 | 32'hFFE0_0000);

        check("R2 svc_req raised", {31'd0, svc_req}, 32'd1);
        check("R2 svc_cmd", {24'd0, svc_cmd}, {24'd0, op});
        check("R2 svc_sub", {28'd0, svc_sub}, {28'd0, sb});
        check("R2 svc_len", {27'd0, svc_len}, {27'd0, ln});
        check("R7 svc_sptr", svc_sptr, sp);
        check("R7 svc_dptr", svc_dptr, dp);
        for (int i = 0; i < NW; i++) check("R8 svc_wbuf word", svc_wbuf[i*32 +: 32], wpat(e, q, i));
        hread(OFS_CMD, r);  check("R2 command readback", r, cw);
        hread(OFS_STS, r);  check("R4 status busy, error cleared", r, 32'd1);
        hread(OFS_SPTR, r); check("R7 sptr readback", r, sp);
        hread(OFS_DPTR, r); check("R7 dptr readback", r, dp);
        hread(8'(OFS_WBUF + 4*(e % NW)), r); check("R8 wbuf readback", r, wpat(e, q, e % NW));

        hwrite(OFS_CMD, 32'h0000_00EE);
        hwrite(OFS_SPTR, 32'hDEAD_0001);
        hwrite(OFS_DPTR, 32'hDEAD_0002);
        hwrite(OFS_WBUF, 32'hDEAD_0003);
        check("R6 cmd write while busy", {24'd0, svc_cmd}, {24'd0, op});
        check("R6 sptr write while busy", svc_sptr, sp);
        check("R6 dptr write while busy", svc_dptr, dp);
        check("R6 wbuf write while busy", svc_wbuf[31:0], wpat(e, q, 0));
        repeat (3) @(negedge clk);
        check("R3 busy held without done", {31'd0, svc_req}, 32'd1);
        check("R5 no irq while busy", {31'd0, irq}, 32'd0);

        for (int i = 0; i < NW; i++) rdat[i*32 +: 32] = rpat(e, q, i);
        complete(e != 0, (e != 0) ? 8'(e) : 8'h5A, rdat);
        code_exp = (e != 0) ? 8'(e) : 8'h00;
        sts_exp = (32'(code_exp) << 16) | (32'(q) << 2) | (32'(e != 0) << 1);
        check("R3 busy drops on done", {31'd0, svc_req}, 32'd0);
        check("R5 irq after done", {31'd0, irq}, 32'(q));
        hread(OFS_STS, r); check("R4 status after done", r, sts_exp);
        for (int i = 0; i < NW; i++) begin
          hread(8'(OFS_RBUF + 4*i), r); check("R9 rbuf word", r, rpat(e, q, i));
        end
        hwrite(OFS_RBUF, 32'h0BAD_0BAD);
        hread(OFS_RBUF, r); check("R9 rbuf host write ignored", r, rpat(e, q, 0));

        hwrite(OFS_STS, 32'hFFFF_FFFB);
        check("R5 status write without bit 2", {31'd0, irq}, 32'(q));
        hwrite(OFS_STS, 32'h0000_0004);
        check("R5 write-1-to-clear", {31'd0, irq}, 32'd0);
        sts_exp = sts_exp & ~32'h4;

        complete(1'b1, 8'hFF, {NW{32'h7777_7777}});
        hread(OFS_STS, r); check("R11 idle done status unchanged", r, sts_exp);
        check("R11 idle done no irq", {31'd0, irq}, 32'd0);
        hread(OFS_RBUF, r); check("R11 idle done rbuf unchanged", r, rpat(e, q, 0));
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule